// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block sequences hardware repeat loops for an in-order DSP pipeline with 16-bit instructions. It holds three loop registers: a start pointer, an end pointer and a pass counter. On every executed instruction it compares the current program address with the loop bottom. When the bottom is reached and passes remain, it steers fetch back to the loop top and counts down, so the loop costs no branch cycles.

The start and end pointers do not always hold the plain top and bottom addresses. What they hold depends on how many instructions the loop contains, and the block rebuilds the real top and bottom from the pointers and a loop-length input. For each instruction it also reports how freely an interrupt may be taken, because the last few instructions before a loop-back cannot be split. The same class gates an interrupt request into an accept signal.

Top module: `zol_ctrl`

## Requirements
- R1: After reset the start pointer, end pointer and counter are zero, `rc_o` is 0, `iclass_o` is 0 (accept any) and `redirect_o` is low.
- R2: A write with `wr_en_i` high loads the start pointer when `wr_sel_i`=0, the end pointer when 1, and the counter (low bits of `wr_data_i`) when 2. The value takes effect for the instruction in the following cycle. `wr_sel_i`=3 changes nothing.
- R3: For a loop length of 4 or more, the top is the start pointer and the bottom is the end pointer plus 2. An executed instruction (`valid_i` high) at the bottom with counter above 1 raises `redirect_o` in the same cycle, with `redirect_addr_o` equal to the top.
- R4: An executed instruction at the bottom with counter at least 1 decrements the counter by one at the next edge. With counter exactly 1 there is no redirect, fetch falls through, and the counter becomes 0.
- R5: For loop lengths 1, 2 and 3, the top is the end pointer minus 2. The bottom is the end pointer minus 2, the end pointer, and the end pointer plus 2 respectively. The start pointer is not used.
- R6: With `valid_i` low, or with the address not at the bottom, there is no redirect and the counter keeps its value.
- R7: With counter at 0 or 1, `iclass_o` is 0 (accept any) for every address.
- R8: Length 5 or more, counter above 1: the address 6 bytes before the bottom is class 1 (accept some). The addresses 4 and 2 before the bottom, and the bottom itself, are class 2 (restricted). All others are class 0.
- R9: Length 4, counter above 1: the address 2 before the top is class 1, and the top plus 0, 2 and 4 are class 2. All others, including the bottom, are class 0.
- R10: Length 1 to 3, counter above 1: the address 2 before the top is class 1, and the top and top plus 2 are class 2. All others are class 0.
- R11: `irq_accept_o` is high when `irq_req_i` is high and either the class is 0, or the class is 1 and `irq_hi_i` is high. It is low in class 2.
- R12: A counter write in the same cycle as a bottom pass wins. The counter takes the written value, not the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction at `pc_i` executes this cycle |
| pc_i | input | ADDR_W | Current instruction address |
| len_i | input | LEN_W | Number of instructions in the loop (saturating) |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 start, 1 end, 2 counter, 3 none |
| wr_data_i | input | ADDR_W | Register write data |
| irq_req_i | input | 1 | Pending interrupt request |
| irq_hi_i | input | 1 | Pending request is high priority |
| redirect_o | output | 1 | Redirect fetch to loop top |
| redirect_addr_o | output | ADDR_W | Loop top address |
| rc_o | output | RC_W | Current counter value |
| iclass_o | output | 2 | Acceptance class: 0 any, 1 some, 2 restricted |
| irq_accept_o | output | 1 | Interrupt may be taken on this instruction |

## Verification
Loops of one to six instructions are each run from just before the top to past the bottom, with the pointers set by the length-dependent rule and several counter values. This separates the three pointer decodings and the three class layouts, and confirms that the last pass falls through. The interrupt priority alternates with the address, so the accept output is seen in every class with both priorities. Directed cases separate a write-wins collision from a plain decrement, an idle bottom address from an executed one, and the unused select code from a real write.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [1:0] {
    ICLS_ANY  = 2'd0,
    ICLS_SOME = 2'd1,
    ICLS_HOLD = 2'd2
  } iclass_e;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_END   = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;
endpackage

// File: rtl/zol_regs.sv
module zol_regs
  import zol_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RC_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              pass_i,
  output logic [ADDR_W-1:0] rs_o,
  output logic [ADDR_W-1:0] re_o,
  output logic [RC_W-1:0]   rc_o
);
  logic wr_rc;
  assign wr_rc = wr_en_i && (wr_sel_i == SEL_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_o <= '0;
      re_o <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_START) rs_o <= wr_data_i;
      if (wr_sel_i == SEL_END)   re_o <= wr_data_i;
    end
  end

  // write beats the loop-back decrement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rc_o <= '0;
    else if (wr_rc)  rc_o <= wr_data_i[RC_W-1:0];
    else if (pass_i) rc_o <= rc_o - 1'b1;
  end

  AST_RC_DEC_ON_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_i && !wr_rc) |=> (rc_o == RC_W'($past(rc_o) - 1'b1))); // R4
  AST_RC_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rc |=> (rc_o == $past(wr_data_i[RC_W-1:0]))); // R12
  AST_RC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_i && !wr_rc) |=> $stable(rc_o)); // R6
endmodule

// File: rtl/zol_bounds.sv
module zol_bounds #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] rs_i,
  input  logic [ADDR_W-1:0] re_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] top_o,
  output logic [ADDR_W-1:0] bot_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic short_loop;
  assign short_loop = (len_i < LEN_W'(4));

  always_comb begin
    top_o = short_loop ? (re_i - STEP) : rs_i;
    if (len_i <= LEN_W'(1))      bot_o = re_i - STEP;
    else if (len_i == LEN_W'(2)) bot_o = re_i;
    else                         bot_o = re_i + STEP;
  end
endmodule

// File: rtl/zol_class.sv
module zol_class
  import zol_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] top_i,
  input  logic [ADDR_W-1:0] bot_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              active_i,
  input  logic              irq_req_i,
  input  logic              irq_hi_i,
  output iclass_e           cls_o,
  output logic              accept_o
);
  localparam logic [ADDR_W-1:0] W2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] W4 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] W6 = ADDR_W'(6);

  logic [ADDR_W-1:0] some_addr;
  logic              hold_hit;

  always_comb begin
    if (len_i >= LEN_W'(5)) begin
      some_addr = bot_i - W6;
      hold_hit  = (pc_i == bot_i - W4) || (pc_i == bot_i - W2) || (pc_i == bot_i);
    end else if (len_i == LEN_W'(4)) begin
      some_addr = top_i - W2;
      hold_hit  = (pc_i == top_i) || (pc_i == top_i + W2) || (pc_i == top_i + W4);
    end else begin
      some_addr = top_i - W2;
      hold_hit  = (pc_i == top_i) || (pc_i == top_i + W2);
    end
  end

  always_comb begin
    cls_o = ICLS_ANY;
    if (active_i) begin
      if (hold_hit)               cls_o = ICLS_HOLD;
      else if (pc_i == some_addr) cls_o = ICLS_SOME;
    end
  end

  assign accept_o = irq_req_i &&
                    ((cls_o == ICLS_ANY) || ((cls_o == ICLS_SOME) && irq_hi_i));

  AST_IDLE_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (cls_o == ICLS_ANY)); // R7
  AST_NO_REQ_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_i |-> !accept_o); // R11
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RC_W   = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              irq_req_i,
  input  logic              irq_hi_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic [RC_W-1:0]   rc_o,
  output logic [1:0]        iclass_o,
  output logic              irq_accept_o
);
  logic [ADDR_W-1:0] rs_q, re_q, top, bot;
  logic              at_bot, pass, active;
  iclass_e           cls;

  zol_regs #(.ADDR_W(ADDR_W), .RC_W(RC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .pass_i(pass), .rs_o(rs_q), .re_o(re_q), .rc_o(rc_o)
  );

  zol_bounds #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_bounds (
    .rs_i(rs_q), .re_i(re_q), .len_i(len_i), .top_o(top), .bot_o(bot)
  );

  assign active = (rc_o > RC_W'(1));
  assign at_bot = valid_i && (pc_i == bot);
  assign pass   = at_bot && (rc_o != '0);

  zol_class #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_class (
    .clk_i, .rst_ni, .pc_i, .top_i(top), .bot_i(bot), .len_i(len_i),
    .active_i(active), .irq_req_i, .irq_hi_i, .cls_o(cls), .accept_o(irq_accept_o)
  );

  assign redirect_o      = at_bot && active;
  assign redirect_addr_o = top;
  assign iclass_o        = cls;

  AST_LAST_PASS_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass && !redirect_o && !wr_en_i) |=> (rc_o == '0)); // R4
  AST_REDIR_LEAVES_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !wr_en_i) |=> (rc_o != '0)); // R3
  AST_REDIR_NOT_ANY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && len_i >= LEN_W'(5)) |-> (iclass_o == 2'd2)); // R8
endmodule

// File: tb/zol_ctrl_tb.sv
`timescale 1ns/1ps
module zol_ctrl_tb;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int LW = 3;
  localparam int NV = 6;
  localparam int LEN_T [NV] = '{1, 2, 3, 4, 5, 6};
  localparam int RC_T  [NV] = '{3, 2, 4, 3, 2, 3};
  localparam int S0_T  [NV] = '{'h100, 'h200, 'h300, 'h400, 'h500, 'h600};

  logic clk = 0, rst_n = 0;
  logic valid = 0, wr_en = 0, irq_req = 0, irq_hi = 0;
  logic [AW-1:0] pc = '0, wr_data = '0;
  logic [LW-1:0] len = LW'(1);
  logic [1:0] wr_sel = 2'd3;
  logic redir, acc;
  logic [AW-1:0] raddr;
  logic [CW-1:0] rc;
  logic [1:0] icls;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  zol_ctrl #(.ADDR_W(AW), .RC_W(CW), .LEN_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc), .len_i(len),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .irq_req_i(irq_req), .irq_hi_i(irq_hi), .redirect_o(redir),
    .redirect_addr_o(raddr), .rc_o(rc), .iclass_o(icls), .irq_accept_o(acc)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; wr_sel = 2'd3;
  endtask

  // expected class from R7..R10
  function automatic logic [1:0] exp_cls(int n, logic [AW-1:0] p, logic [AW-1:0] t,
                                         logic [AW-1:0] b, int r);
    if (r <= 1) return 2'd0;
    if (n >= 5) begin
      if (p == b - 6) return 2'd1;
      if (p == b - 4 || p == b - 2 || p == b) return 2'd2;
    end else if (n == 4) begin
      if (p == t - 2) return 2'd1;
      if (p == t || p == t + 2 || p == t + 4) return 2'd2;
    end else begin
      if (p == t - 2) return 2'd1;
      if (p == t || p == t + 2) return 2'd2;
    end
    return 2'd0;
  endfunction

  // pointer values per length rule (R3, R5)
  task automatic setup(input int n, input logic [AW-1:0] s0, input int r);
    logic [AW-1:0] t, b;
    t = s0 + 2; b = t + AW'(2 * (n - 1));
    len = LW'(n);
    case (n)
      1: begin wr(2'd0, s0 + 8); wr(2'd1, s0 + 4); end
      2: begin wr(2'd0, s0 + 6); wr(2'd1, s0 + 4); end
      3: begin wr(2'd0, s0 + 4); wr(2'd1, s0 + 4); end
      default: begin wr(2'd0, t); wr(2'd1, b - 2); end
    endcase
    wr(2'd2, AW'(r));
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0] t, b, p;
    int r, n;
    logic er;
    logic [1:0] ec;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    valid = 1; pc = '0;
    #1;
    chk("R1 rc", AW'(rc), '0);
    chk("R1 cls", AW'(icls), '0);
    chk("R1 redir", AW'(redir), '0);
    valid = 0;
    rst_n = 1;
    @(posedge clk); #1;

    // table walk over loop lengths 1..6
    for (int v = 0; v < NV; v++) begin
      n = LEN_T[v]; r = RC_T[v];
      t = S0_T[v] + 2; b = t + AW'(2 * (n - 1));
      setup(n, AW'(S0_T[v]), r);
      irq_req = 1;
      p = AW'(S0_T[v]) - 2;
      for (int s = 0; s < 60 && p <= b + 4; s++) begin
        valid = 1; pc = p; irq_hi = p[2];
        #1;
        er = (p == b) && (r > 1);
        ec = exp_cls(n, p, t, b, r);
        chk(n >= 4 ? "R3 redir" : "R5 redir", AW'(redir), AW'(er));
        if (er) chk(n >= 4 ? "R3 target" : "R5 target", raddr, t);
        chk(n >= 5 ? "R8 cls" : (n == 4 ? "R9 cls" : "R10 cls"), AW'(icls), AW'(ec));
        chk("R4 rc", AW'(rc), AW'(r));
        chk("R11 accept", AW'(acc), AW'((ec == 2'd0) || (ec == 2'd1 && irq_hi)));
        @(posedge clk); #1;
        if (p == b && r >= 1) r--;
        p = er ? t : p + 2;
      end
      chk("R4 end rc", AW'(rc), '0);
      valid = 0; irq_req = 0;
    end

    // R2 unused select has no effect; R7 at rc 1
    setup(4, AW'('h800), 5);
    wr(2'd3, AW'('h1234));
    chk("R2 sel3 rc", AW'(rc), AW'(5));
    valid = 1; pc = AW'('h808); #1;
    chk("R2 sel3 redir", AW'(redir), 1);
    chk("R2 sel3 target", raddr, AW'('h802));
    valid = 0;
    // R6 idle at bottom
    #1;
    chk("R6 no redir", AW'(redir), 0);
    @(posedge clk); #1;
    chk("R6 rc held", AW'(rc), AW'(5));
    // R12 write collides with a pass
    valid = 1; pc = AW'('h808);
    wr(2'd2, AW'(9));
    valid = 0;
    chk("R12 rc", AW'(rc), AW'(9));
    // R2 write visible next cycle
    wr(2'd2, AW'(1));
    chk("R2 rc write", AW'(rc), AW'(1));
    // R7 rc=1 class any; R4 last pass
    valid = 1; pc = AW'('h802); #1;
    chk("R7 cls", AW'(icls), 0);
    pc = AW'('h808); #1;
    chk("R4 last no redir", AW'(redir), 0);
    @(posedge clk); #1;
    valid = 0;
    chk("R4 last rc", AW'(rc), 0);
    // R11 restricted blocks high priority
    wr(2'd2, AW'(4));
    valid = 1; pc = AW'('h804); irq_req = 1; irq_hi = 1; #1;
    chk("R11 hold", AW'(acc), 0);
    pc = AW'('h800); #1;
    chk("R11 some hi", AW'(acc), 1);
    irq_hi = 0; #1;
    chk("R11 some lo", AW'(acc), 0);
    valid = 0; irq_req = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule